// File: doc/BRIEF.md
# Self-Sequencing DRAM Page Command Generator

This block emits, every clock, the command that keeps a burst-mode synchronous DRAM streaming through every page of memory without a host in the loop. A column position counter walks across the current page one column per cycle. In the final cycles of each page, four command slots fire in a fixed order: precharge, activate, read, write. Those four commands close the bank that the next page will use, open it at the next row, and start full-page bursts there. The next page's burst therefore follows the current one with no idle cycle.

Two command targets share the one stream. The primary bank group always receives precharge, activate and read, and never receives a write. The secondary group always receives precharge and activate. Its read or write is gated by a mode bit: repeat mode passes the read and sample mode passes the write. The read slot sits ahead of the write slot by the CAS latency, so read data and write data both meet column 0 of the next page in the same cycle. The mode input is latched once per pass through memory. A trigger output marks the cycle in which the pass restarts at its first page.

Pages are visited bank first: the bank index rotates every page, and the row advances each time the bank index wraps. After reset the position is the last column-0 of the last page. The first commands issued therefore open page 0.

Top module: `dram_page_sequencer`

## Requirements
- R1: After reset, with run low, both command outputs are NOP, the trigger is low, and once running the first activate opens bank 0, row 0.
- R2: At column COLS-1-CAS_LAT-2*CMD_GAP both targets get precharge, addressed to the next page's bank with row (next row - 1). At column COLS-1-CAS_LAT-CMD_GAP both get activate, addressed to the next bank and next row.
- R3: At column COLS-1-CAS_LAT the primary target gets a read, and the secondary gets a read only when the latched mode is 1 (repeat). The address is the next page's bank and column 0.
- R4: At column COLS-1 the secondary target gets a write only when the latched mode is 0 (sample). The address is the next page's bank and column 0. The primary target never receives a write.
- R5: While running, the column advances by one each cycle and wraps from COLS-1 to 0 with no gap. On each wrap the bank index increments by one. The row increments when the bank wraps from its maximum to 0, and the last page is followed by bank 0, row 0.
- R6: Commands use {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACT 0011, RD 0101, WR 0100, PRE 0010. Every cycle without a scheduled command carries NOP on both targets.
- R7: The mode input is sampled only in the precharge-slot cycle of the last page of a pass. A mode change at any other time has no effect on read/write gating until that point.
- R8: The trigger is high while running at bank 0, row 0, column 0, which is one cycle per uninterrupted pass.
- R9: While run is low the position holds, both targets get NOP, and the trigger is low. Resuming continues from the held position.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Advance the sequence and issue commands when high |
| mode_i | input | 1 | 0 = sample (secondary writes), 1 = repeat (secondary reads) |
| pri_cmd_o | output | 4 | Primary target command {cs_n, ras_n, cas_n, we_n} |
| sec_cmd_o | output | 4 | Secondary target command {cs_n, ras_n, cas_n, we_n} |
| bank_o | output | BANK_W | Bank address of the current command, 0 on NOP |
| row_o | output | ROW_W | Row address for precharge/activate, 0 otherwise |
| col_o | output | clog2(COLS) | Column address of read/write, always 0 |
| trig_o | output | 1 | Pass-start marker |

## Verification
The assertions check several rules on every cycle. The primary target never sees a write. The secondary read and write follow the latched mode. Precharge and activate always reach both targets together. The column steps and wraps without a gap. The position freezes while run is low. The latched mode changes only in the latch cycle. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers the exact slot columns, the next-page bank and row arithmetic across row wrap and the end of a pass, and the trigger timing. It also covers mid-pass mode changes that must stay invisible until the next pass, and a pause and resume in the middle of a page.

// File: rtl/dps_pkg.sv
package dps_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } cmd_e;

    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_PRE,
        SLOT_ACT,
        SLOT_RD,
        SLOT_WR
    } slot_e;

endpackage

// File: rtl/dps_position.sv
module dps_position #(
    parameter int COLS      = 1024,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 13,
    parameter int LATCH_COL = 1017,
    localparam int COL_W    = $clog2(COLS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              mode_i,
    output logic [COL_W-1:0]  col_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              mode_o
);

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic              mode;
    } pos_t;

    pos_t st_d, st_q;
    logic last_page;

    assign last_page = (st_q.bank == '1) && (st_q.row == '1);

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            if (last_page && st_q.col == COL_W'(LATCH_COL)) begin
                st_d.mode = mode_i;
            end
            if (st_q.col == COL_W'(COLS - 1)) begin
                st_d.col  = '0;
                st_d.bank = st_q.bank + BANK_W'(1);
                if (st_q.bank == '1) begin
                    st_d.row = st_q.row + ROW_W'(1);
                end
            end else begin
                st_d.col = st_q.col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.col  <= '0;
            st_q.bank <= '1;
            st_q.row  <= '1;
            st_q.mode <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o  = st_q.col;
    assign bank_o = st_q.bank;
    assign row_o  = st_q.row;
    assign mode_o = st_q.mode;

    p_col_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && st_q.col != COL_W'(COLS - 1)) |=> (st_q.col == $past(st_q.col) + COL_W'(1)));

    p_page_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && st_q.col == COL_W'(COLS - 1))
            |=> (st_q.col == '0 && st_q.bank == $past(st_q.bank) + BANK_W'(1)));

    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> ($stable(st_q.col) && $stable(st_q.bank) && $stable(st_q.row)));

    p_mode_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.mode) |-> ($past(st_q.col) == COL_W'(LATCH_COL)));

endmodule

// File: rtl/dps_slot_decode.sv
module dps_slot_decode
    import dps_pkg::*;
#(
    parameter int COL_W    = 10,
    parameter int PRE_SLOT = 1017,
    parameter int ACT_SLOT = 1019,
    parameter int RD_SLOT  = 1021,
    parameter int WR_SLOT  = 1023
) (
    input  logic             run_i,
    input  logic [COL_W-1:0] col_i,
    output slot_e            slot_o
);

    always_comb begin
        slot_o = SLOT_NONE;
        if (run_i) begin
            if (col_i == COL_W'(PRE_SLOT))      slot_o = SLOT_PRE;
            else if (col_i == COL_W'(ACT_SLOT)) slot_o = SLOT_ACT;
            else if (col_i == COL_W'(RD_SLOT))  slot_o = SLOT_RD;
            else if (col_i == COL_W'(WR_SLOT))  slot_o = SLOT_WR;
        end
    end

endmodule

// File: rtl/dps_target_gate.sv
module dps_target_gate
    import dps_pkg::*;
#(
    parameter bit SECONDARY = 1'b0
) (
    input  slot_e slot_i,
    input  logic  mode_i,
    output cmd_e  cmd_o
);

    cmd_e rw_cmd;

    generate
        if (SECONDARY) begin : g_sec
            always_comb begin
                rw_cmd = CMD_NOP;
                if (slot_i == SLOT_RD && mode_i)       rw_cmd = CMD_RD;
                else if (slot_i == SLOT_WR && !mode_i) rw_cmd = CMD_WR;
            end
        end else begin : g_pri
            always_comb begin
                rw_cmd = CMD_NOP;
                if (slot_i == SLOT_RD) rw_cmd = CMD_RD;
            end
        end
    endgenerate

    always_comb begin
        unique case (slot_i)
            SLOT_PRE: cmd_o = CMD_PRE;
            SLOT_ACT: cmd_o = CMD_ACT;
            SLOT_RD,
            SLOT_WR:  cmd_o = rw_cmd;
            default:  cmd_o = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/dram_page_sequencer.sv
module dram_page_sequencer
    import dps_pkg::*;
#(
    parameter int COLS    = 1024,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 13,
    parameter int CAS_LAT = 2,
    parameter int CMD_GAP = 2,
    localparam int COL_W  = $clog2(COLS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              mode_i,
    output logic [3:0]        pri_cmd_o,
    output logic [3:0]        sec_cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              trig_o
);

    localparam int WR_SLOT  = COLS - 1;
    localparam int RD_SLOT  = WR_SLOT - CAS_LAT;
    localparam int ACT_SLOT = RD_SLOT - CMD_GAP;
    localparam int PRE_SLOT = ACT_SLOT - CMD_GAP;

    logic [COL_W-1:0]  cur_col;
    logic [BANK_W-1:0] cur_bank;
    logic [ROW_W-1:0]  cur_row;
    logic              mode_q;
    logic [BANK_W-1:0] nxt_bank;
    logic [ROW_W-1:0]  nxt_row;
    logic [ROW_W-1:0]  old_row;
    slot_e             slot;
    cmd_e              pri_cmd;
    cmd_e              sec_cmd;

    dps_position #(
        .COLS      (COLS),
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W),
        .LATCH_COL (PRE_SLOT)
    ) u_pos (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_i),
        .mode_i (mode_i),
        .col_o  (cur_col),
        .bank_o (cur_bank),
        .row_o  (cur_row),
        .mode_o (mode_q)
    );

    dps_slot_decode #(
        .COL_W    (COL_W),
        .PRE_SLOT (PRE_SLOT),
        .ACT_SLOT (ACT_SLOT),
        .RD_SLOT  (RD_SLOT),
        .WR_SLOT  (WR_SLOT)
    ) u_slot (
        .run_i  (run_i),
        .col_i  (cur_col),
        .slot_o (slot)
    );

    dps_target_gate #(.SECONDARY(1'b0)) u_pri (
        .slot_i (slot),
        .mode_i (mode_q),
        .cmd_o  (pri_cmd)
    );

    dps_target_gate #(.SECONDARY(1'b1)) u_sec (
        .slot_i (slot),
        .mode_i (mode_q),
        .cmd_o  (sec_cmd)
    );

    // Next page: bank rotates, row steps when the bank index wraps.
    always_comb begin
        nxt_bank = cur_bank + BANK_W'(1);
        nxt_row  = (cur_bank == '1) ? cur_row + ROW_W'(1) : cur_row;
        old_row  = nxt_row - ROW_W'(1);
    end

    always_comb begin
        bank_o = '0;
        row_o  = '0;
        col_o  = '0;
        if (slot != SLOT_NONE) begin
            bank_o = nxt_bank;
        end
        if (slot == SLOT_PRE) row_o = old_row;
        if (slot == SLOT_ACT) row_o = nxt_row;
    end

    assign pri_cmd_o = pri_cmd;
    assign sec_cmd_o = sec_cmd;
    assign trig_o    = run_i && cur_col == '0 && cur_bank == '0 && cur_row == '0;

    p_no_wr_primary_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pri_cmd_o != 4'b0100);

    p_sec_wr_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sec_cmd_o == 4'b0100) |-> (!mode_q && pri_cmd_o == 4'b0111));

    p_sec_rd_repeat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sec_cmd_o == 4'b0101) |-> (mode_q && pri_cmd_o == 4'b0101));

    p_pre_both_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pri_cmd_o == 4'b0010) |-> (sec_cmd_o == 4'b0010));

    p_act_both_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pri_cmd_o == 4'b0011) |-> (sec_cmd_o == 4'b0011));

    p_idle_nop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> (pri_cmd_o == 4'b0111 && sec_cmd_o == 4'b0111 && !trig_o));

    p_trig_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_o && run_i) |=> !trig_o);

endmodule

// File: tb/dram_page_sequencer_bench.sv
`timescale 1ns/1ps
module dram_page_sequencer_bench;

    localparam int COLS    = 16;
    localparam int ROW_W   = 2;
    localparam int CAS_LAT = 2;
    localparam int CMD_GAP = 2;
    localparam int NB      = 4;
    localparam int ROWS    = 1 << ROW_W;
    localparam int NPAGES  = NB * ROWS;
    localparam int PASS    = NPAGES * COLS;
    localparam int S_WR    = COLS - 1;
    localparam int S_RD    = S_WR - CAS_LAT;
    localparam int S_ACT   = S_RD - CMD_GAP;
    localparam int S_PRE   = S_ACT - CMD_GAP;
    localparam int LATCH_POS = PASS - COLS + S_PRE;

    localparam logic [3:0] E_NOP = 4'b0111;
    localparam logic [3:0] E_ACT = 4'b0011;
    localparam logic [3:0] E_RD  = 4'b0101;
    localparam logic [3:0] E_WR  = 4'b0100;
    localparam logic [3:0] E_PRE = 4'b0010;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       mode = 1'b0;
    logic [3:0] pri_cmd, sec_cmd;
    logic [1:0] bank;
    logic [ROW_W-1:0] row;
    logic [3:0] col;
    logic       trig;

    int checks = 0;
    int errors = 0;
    int pos = PASS - COLS;
    bit mmode = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_page_sequencer #(
        .COLS(COLS), .BANK_W(2), .ROW_W(ROW_W), .CAS_LAT(CAS_LAT), .CMD_GAP(CMD_GAP)
    ) u_dram_page_sequencer (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .mode_i(mode),
        .pri_cmd_o(pri_cmd), .sec_cmd_o(sec_cmd), .bank_o(bank),
        .row_o(row), .col_o(col), .trig_o(trig)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: a flat position counter over the whole pass.
    always @(posedge clk) begin
        if (!rst_n) begin
            pos   = PASS - COLS;
            mmode = 1'b0;
        end else if (run) begin
            if (pos == LATCH_POS) mmode = mode;
            pos = (pos + 1) % PASS;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int page, c, np, nb, nr, pr;
            logic [3:0] ep, es;
            string tag;
            page = pos / COLS;
            c    = pos % COLS;
            np   = (page + 1) % NPAGES;
            nb   = np % NB;
            nr   = np / NB;
            pr   = (nr + ROWS - 1) % ROWS;
            ep   = E_NOP;
            es   = E_NOP;
            tag  = run ? "R6" : "R9";
            if (run) begin
                if (c == S_PRE) begin ep = E_PRE; es = E_PRE; tag = "R2"; end
                else if (c == S_ACT) begin ep = E_ACT; es = E_ACT; tag = "R2"; end
                else if (c == S_RD) begin ep = E_RD; es = mmode ? E_RD : E_NOP; tag = "R3/R7"; end
                else if (c == S_WR) begin ep = E_NOP; es = mmode ? E_NOP : E_WR; tag = "R4/R7"; end
            end
            chk(pri_cmd == ep, {tag, " primary cmd"}, pri_cmd, ep);
            chk(sec_cmd == es, {tag, " secondary cmd"}, sec_cmd, es);
            chk(trig == (run && pos == 0), "R8 trigger", trig, (run && pos == 0));
            if (run && (c == S_PRE || c == S_ACT || c == S_RD || c == S_WR))
                chk(bank == nb, "R5 next-page bank", bank, nb);
            if (run && c == S_PRE) chk(row == pr, "R2 precharge row", row, pr);
            if (run && c == S_ACT) chk(row == nr, "R2/R5 activate row", row, nr);
            if (run && (c == S_RD || c == S_WR)) chk(col == 0, "R3/R4 burst column", col, 0);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        step(3);
        // R1: reset state
        chk(pri_cmd == E_NOP, "R1 reset primary", pri_cmd, E_NOP);
        chk(sec_cmd == E_NOP, "R1 reset secondary", sec_cmd, E_NOP);
        chk(trig == 1'b0, "R1 reset trigger", trig, 0);
        rst_n = 1'b1;
        step(2);
        run = 1'b1;
        // R1: first activate opens bank 0 row 0
        step(S_ACT);
        chk(pri_cmd == E_ACT && bank == 0 && row == 0, "R1 first activate", {pri_cmd, bank, row}, {E_ACT, 4'b0});
        step(600);
        mode = 1'b1;            // mid-pass change, R7: invisible until latch
        step(310);
        run = 1'b0;             // R9: pause mid-page
        step(20);
        run = 1'b1;
        step(137);
        mode = 1'b0;
        step(5);
        mode = 1'b1;            // flip back before latch point
        step(400);
        mode = 1'b0;
        step(600);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule